// File: doc/BRIEF.md
# Prescaled Modulo Timer

This block is a 16-bit up-counting timer placed on a simple 32-bit word-addressed register bus. A control word chooses whether the counter runs from the system clock, and sets a power-of-two prescaler. The counter climbs from a programmable start value to a programmable limit. On the tick after it reaches the limit it returns to the start value, and it raises an overflow flag that can drive an interrupt line.

The limit and the start value each sit behind a write buffer. The counter only adopts new values while it is stopped. Software can therefore stage a new period during a run without tearing the current one. A write of any data to the counter register restarts the count from the committed start value. This gives a one-write way to begin a fresh period.

Top module: `pmt_top`

## Requirements
- R1: After reset the control word reads 0x00, the counter reads 0, the modulo register reads 0x0000FFFF, the start-value register reads 0 and `irq` is low.
- R2: Word address 0 is control, 1 is counter, 2 is modulo and 19 is start value. Any other address reads 0. Control fields are: bits [2:0] prescale select, bits [4:3] source (1 = system clock; 0, 2 and 3 = stopped), bit 6 interrupt enable, bit 7 overflow flag.
- R3: With source 1, the first counter increment comes exactly 2^select clock cycles after the enabling control write. Later increments follow every 2^select cycles.
- R4: The counter increments until it equals the active modulo value and then reloads the active start value. One period lasts (modulo − start + 1) × 2^select cycles.
- R5: The overflow flag becomes 1 on the same clock edge at which the counter reloads from modulo to start.
- R6: A write to the counter register loads the active start value and ignores the written data.
- R7: Writes to modulo and start value go to buffers. Reads of those registers return the active values. The active values take the buffered values only on cycles where the source field is 0.
- R8: A counter read returns the count in bits [15:0] with bits [31:16] zero.
- R9: The flag clears only when control is written with bit 7 = 0 after a control read that returned bit 7 = 1. A write of 0 without that read does not clear it, a write of 1 does not set it, and a flag set in the same cycle as a clear stays set.
- R10: `irq` is high exactly while both the flag and the interrupt enable are 1, and it stays high until the flag is cleared.
- R11: A control write that changes the prescale select restarts the prescaler, so the first increment after it takes the full new division.
- R12: While the source is not 1, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Overflow interrupt request, level |

## Verification
On every cycle the assertions check the following:
- each reload lands on the start value and sets the flag;
- each plain tick adds exactly one;
- a counter write loads the start value;
- the active modulo and start values stay frozen while the source is non-zero;
- a stopped counter holds its value;
- a set flag and a raised interrupt persist until a clear.

Only the directed scenarios can show the following:
- the cycle counts from enable to the first increment, and between reloads, for several prescale values;
- the restart of the prescaler on a select change;
- the read-then-write handshake that clears the flag;
- the reset values and the address map.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  localparam int ADR_CTRL = 0;
  localparam int ADR_CNT  = 1;
  localparam int ADR_MOD  = 2;
  localparam int ADR_INIT = 19;

  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_RSV2 = 2'd2,
    SRC_RSV3 = 2'd3
  } src_e;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       rsv;
    src_e       src;
    logic [2:0] ps;
  } ctrl_t;

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int PC_W  = (1 << PS_W) - 1;
  localparam int PCX_W = PC_W + 1;

  logic [PC_W-1:0] pre_q;
  logic [PC_W-1:0] last;

  function automatic logic [PC_W-1:0] last_count(input logic [PS_W-1:0] sel);
    logic [PCX_W-1:0] span;
    span = PCX_W'(1) << sel;
    return PC_W'(span - PCX_W'(1));
  endfunction

  assign last = last_count(ps);
  assign tick = run && (pre_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (!run || restart) pre_q <= '0;
    else if (tick)           pre_q <= '0;
    else                     pre_q <= pre_q + PC_W'(1);
  end
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] mod_lim,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] lim,
                                            input logic [CNT_W-1:0] start);
    return (cur == lim) ? start : cur + CNT_W'(1);
  endfunction

  assign wrap = tick && !load && (cnt == mod_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= init_val;
    else if (tick) cnt <= step(cnt, mod_lim, init_val);
  end
endmodule

// File: rtl/pmt_regs.sv
module pmt_regs #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cnt,
  output logic [PS_W-1:0]   ps,
  output logic              run,
  output logic              ie,
  output logic              flag,
  output logic [CNT_W-1:0]  mod_act,
  output logic [CNT_W-1:0]  init_act,
  output logic              cnt_load,
  output logic              ps_restart,
  output logic              flag_clr,
  output logic              ctrl_wr,
  output logic              buf_commit
);
  import pmt_pkg::*;

  logic [PS_W-1:0]  ps_q;
  src_e             src_q;
  logic             ie_q, flag_q, armed_q;
  logic [CNT_W-1:0] mod_buf, init_buf;
  logic             sel_ctrl, sel_cnt, sel_mod, sel_init;
  logic             wr, rd, ctrl_rd;
  ctrl_t            ctrl_view;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  assign sel_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
  assign sel_cnt  = (bus_addr == ADDR_W'(ADR_CNT));
  assign sel_mod  = (bus_addr == ADDR_W'(ADR_MOD));
  assign sel_init = (bus_addr == ADDR_W'(ADR_INIT));
  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;

  assign ctrl_wr    = wr && sel_ctrl;
  assign ctrl_rd    = rd && sel_ctrl;
  assign cnt_load   = wr && sel_cnt;
  assign ps_restart = ctrl_wr && (bus_wdata[PS_W-1:0] != ps_q);
  assign flag_clr   = ctrl_wr && !bus_wdata[7] && armed_q;
  assign buf_commit = (src_q == SRC_OFF);

  assign ps   = ps_q;
  assign run  = (src_q == SRC_SYS);
  assign ie   = ie_q;
  assign flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      src_q <= SRC_OFF;
      ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      ps_q  <= bus_wdata[PS_W-1:0];
      src_q <= src_e'(bus_wdata[4:3]);
      ie_q  <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed_q <= 1'b0;
    else if (ctrl_wr)          armed_q <= 1'b0;
    else if (ctrl_rd && flag_q) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_buf  <= '1;
      init_buf <= '0;
    end else begin
      if (wr && sel_mod)  mod_buf  <= bus_wdata[CNT_W-1:0];
      if (wr && sel_init) init_buf <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_act  <= '1;
      init_act <= '0;
    end else if (buf_commit) begin
      mod_act  <= mod_buf;
      init_act <= init_buf;
    end
  end

  always_comb begin
    ctrl_view      = '0;
    ctrl_view.flag = flag_q;
    ctrl_view.ie   = ie_q;
    ctrl_view.src  = src_q;
    ctrl_view.ps   = 3'(ps_q);
    bus_rdata      = '0;
    if (sel_ctrl)      bus_rdata = DATA_W'(ctrl_view);
    else if (sel_cnt)  bus_rdata = DATA_W'(cnt);
    else if (sel_mod)  bus_rdata = DATA_W'(mod_act);
    else if (sel_init) bus_rdata = DATA_W'(init_act);
  end
endmodule

// File: rtl/pmt_top.sv
module pmt_top #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [PS_W-1:0]  ps;
  logic             run, ie, flag, tick, wrap;
  logic             cnt_load, ps_restart, flag_clr, ctrl_wr, buf_commit;
  logic [CNT_W-1:0] cnt, mod_act, init_act;

  pmt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wrap(wrap), .cnt(cnt), .ps(ps), .run(run), .ie(ie), .flag(flag),
    .mod_act(mod_act), .init_act(init_act), .cnt_load(cnt_load),
    .ps_restart(ps_restart), .flag_clr(flag_clr), .ctrl_wr(ctrl_wr),
    .buf_commit(buf_commit)
  );

  pmt_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ps_restart),
    .ps(ps), .tick(tick)
  );

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .mod_lim(mod_act), .init_val(init_act), .cnt(cnt), .wrap(wrap)
  );

  assign irq = flag && ie;
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap,
  input logic             run,
  input logic             cnt_load,
  input logic             flag_clr,
  input logic             ctrl_wr,
  input logic             buf_commit,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_act,
  input logic [CNT_W-1:0] init_act
);
  AST_RELOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == $past(init_act)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wrap && !cnt_load |=> cnt == $past(cnt) + CNT_W'(1)); // R4
  AST_FLAG_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R5
  AST_WRITE_LOADS_START: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt == $past(init_act)); // R6
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_commit |=> $stable(mod_act) && $stable(init_act)); // R7
  AST_FLAG_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R9
  AST_IRQ_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !flag_clr && !ctrl_wr |=> irq); // R10
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R3
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_load |=> $stable(cnt)); // R12
endmodule

bind pmt_top pmt_checker #(.CNT_W(CNT_W)) u_pmt_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .run(run),
  .cnt_load(cnt_load), .flag_clr(flag_clr), .ctrl_wr(ctrl_wr),
  .buf_commit(buf_commit), .flag(flag), .irq(irq), .cnt(cnt),
  .mod_act(mod_act), .init_act(init_act)
);

// File: tb/pmt_top_tb.sv
module pmt_top_tb_top;
  localparam int A_CTRL = 0;
  localparam int A_CNT  = 1;
  localparam int A_MOD  = 2;
  localparam int A_INIT = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'(addr); bus_wdata = data;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 5'(addr);
    #1 data = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic peek_cnt(output logic [31:0] v);
    bus_addr = 5'(A_CNT);
    #1 v = bus_rdata;
  endtask

  task automatic clear_flag();
    logic [31:0] c;
    bus_read(A_CTRL, c);
    bus_write(A_CTRL, c & 32'h0000_007F);
  endtask

  task automatic setup(input logic [15:0] start, input logic [15:0] lim);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_INIT, {16'h0, start});
    bus_write(A_MOD, {16'h0, lim});
    bus_write(A_CNT, 32'h0);
  endtask

  task automatic first_step(output int k);
    logic [31:0] base, cur;
    peek_cnt(base);
    k = 0;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      peek_cnt(cur);
      if (cur != base) begin k = i; break; end
    end
  endtask

  task automatic watch_wraps(input logic [15:0] lim, input logic [15:0] start,
                             input int cycles, output int first, output int period,
                             output logic irq_at_wrap);
    logic [31:0] prev, cur;
    int nw = 0;
    first = -1; period = -1; irq_at_wrap = 1'b0;
    peek_cnt(prev);
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      peek_cnt(cur);
      if (prev == {16'h0, lim} && cur == {16'h0, start}) begin
        if (nw == 0) begin first = i; irq_at_wrap = irq; end
        else if (nw == 1) period = i - first;
        nw++;
      end
      prev = cur;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", 32'(irq), 32'h0);
    bus_read(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    bus_read(A_CNT, v);  check("R1 counter", v, 32'h0);
    bus_read(A_MOD, v);  check("R1 modulo", v, 32'h0000_FFFF);
    bus_read(A_INIT, v); check("R1 start", v, 32'h0);
    bus_read(5, v);      check("R2 unmapped read", v, 32'h0);
  endtask

  task automatic t_count_ps0();
    int first, period;
    logic iw;
    logic [31:0] v;
    setup(16'd2, 16'd5);
    bus_read(A_CNT, v); check("R6 loaded start", v, 32'd2);
    bus_write(A_CTRL, 32'h48);
    watch_wraps(16'd5, 16'd2, 20, first, period, iw);
    check("R3 R4 first reload ps0", 32'(first), 32'd4);
    check("R4 period ps0", 32'(period), 32'd4);
    check("R5 R10 irq at reload", 32'(iw), 32'h1);
    bus_write(A_CTRL, 32'h40);
    check("R9 write 0 without read keeps flag", 32'(irq), 32'h1);
    bus_read(A_CTRL, v); check("R9 flag reads 1", 32'(v[7]), 32'h1);
    bus_write(A_CTRL, 32'h40);
    check("R9 read then write 0 clears", 32'(irq), 32'h0);
    bus_write(A_CTRL, 32'hC0);
    bus_read(A_CTRL, v); check("R9 write 1 does not set", 32'(v[7]), 32'h0);
  endtask

  task automatic t_count_ps2();
    int k, first, period;
    logic iw;
    setup(16'd0, 16'd3);
    bus_write(A_CTRL, 32'h0A);
    first_step(k);
    check("R3 first step ps2", 32'(k), 32'd4);
    watch_wraps(16'd3, 16'd0, 80, first, period, iw);
    check("R4 period ps2", 32'(period), 32'd16);
    first_step(k);
    bus_write(A_CTRL, 32'h09);
    first_step(k);
    check("R11 restart on select change", 32'(k), 32'd2);
    bus_write(A_CTRL, 32'h0);
    clear_flag();
  endtask

  task automatic t_load();
    logic [31:0] v;
    setup(16'd7, 16'd100);
    bus_write(A_CNT, 32'hFFFF_1234);
    bus_read(A_CNT, v);
    check("R6 R8 write loads start, upper zero", v, 32'h0000_0007);
  endtask

  task automatic t_buffer();
    int first, period;
    logic iw;
    logic [31:0] v;
    setup(16'd0, 16'd3);
    bus_write(A_CTRL, 32'h08);
    bus_write(A_MOD, 32'd9);
    bus_read(A_MOD, v); check("R7 active modulo kept while running", v, 32'd3);
    watch_wraps(16'd3, 16'd0, 20, first, period, iw);
    check("R7 period uses old modulo", 32'(period), 32'd4);
    bus_write(A_CTRL, 32'h0);
    @(negedge clk);
    bus_read(A_MOD, v); check("R7 commit when stopped", v, 32'd9);
  endtask

  task automatic t_irq_mask();
    logic [31:0] v;
    setup(16'd0, 16'd2);
    bus_write(A_CTRL, 32'h08);
    repeat (10) @(negedge clk);
    check("R10 irq masked", 32'(irq), 32'h0);
    bus_write(A_CTRL, 32'h00);
    bus_write(A_CTRL, 32'h40);
    check("R10 irq with enable", 32'(irq), 32'h1);
    bus_read(A_CTRL, v);
    bus_write(A_CTRL, 32'h40);
    check("R10 irq drops on clear", 32'(irq), 32'h0);
  endtask

  task automatic t_stop();
    logic [31:0] a, b;
    setup(16'd5, 16'd50);
    bus_write(A_CTRL, 32'h10);
    peek_cnt(a);
    repeat (12) @(negedge clk);
    peek_cnt(b);
    check("R12 R2 source 2 holds", b, a);
    bus_write(A_CTRL, 32'h00);
    repeat (12) @(negedge clk);
    peek_cnt(b);
    check("R12 source 0 holds", b, a);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_ps0();
    t_count_ps2();
    t_load();
    t_buffer();
    t_irq_mask();
    t_stop();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_run();
    end
  end
endmodule